// File: doc/BRIEF.md
# Shifted-Compute Stencil Beat Packer

This block applies a square box-sum stencil to an image that arrives in raster order as beats of several pixels per clock. Each row of the sliding window holds only the current beat and twice the stencil radius of carried pixels. The compute lanes therefore produce results that sit one radius to the left of the beat that was just accepted. A small holding register keeps the lanes of one compute cycle that belong to the next aligned output beat. The following compute cycle completes that beat, so the block emits output beats that line up with the input beat grid.

Rows above the image and columns outside a row count as zero. The bottom radius rows of the frame produce no output, so each frame yields image-height minus radius output rows. The last beat of every row needs right-hand neighbours that never arrive. A dedicated tail lane computes its final lanes, and one flush cycle later that beat leaves the block. Image size, lanes per beat, radius and pixel width are parameters. Input stalls are allowed between any two beats.

Top module: `stn_pack_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_vld` is 0. While `rst` is high, `out_sum` is 0.
- R2: No output beat is produced while input rows 0 to RADIUS-1 of a frame are being accepted. Output row c is produced while input row c+RADIUS arrives.
- R3: Input lane i (bits [i*PIX_W +: PIX_W]) of input beat b holds pixel x = b*LANES+i. Output lane i (bits [i*SUM_W +: SUM_W]) of output beat k in output row c equals the sum of all pixels at rows c-RADIUS..c+RADIUS and columns x-RADIUS..x+RADIUS, where x = k*LANES+i. Pixels left or right of the row, or above row 0, count as zero. No data carries over from the previous row.
- R4: Output beat k of a row, for k below the last, is valid in the cycle after the clock edge that accepts input beat k+1 of the same row. The last output beat of a row is valid two cycles after the edge that accepts the row's last input beat. Stalls (`in_vld` low) move both.
- R5: Each frame yields exactly (IMG_H-RADIUS)*(IMG_W/LANES) output beats, in raster order. After IMG_H input rows the row count wraps, and the next frame starts at row 0.
- R6: With every pixel at full scale, no lane overflows: SUM_W = PIX_W + ceil(log2((2*RADIUS+1)^2)), which is 12 bits for the defaults.
- R7: In every cycle where `out_vld` is 0, `out_sum` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input beat is accepted at this edge |
| in_pix | input | LANES*PIX_W | Input beat, lane 0 is the leftmost pixel |
| out_vld | output | 1 | Output beat valid for one cycle |
| out_sum | output | LANES*SUM_W | Aligned output beat of stencil sums, lane 0 leftmost |

## Verification
The bound checker watches the timing contract on every cycle. An inner input beat in an output row must yield a valid beat one cycle later, and a last beat must yield one two cycles later. The checker also confirms that nothing appears during the top rows, that the outputs stay quiet after reset, and that `out_sum` holds while invalid. The arithmetic can only be shown by the bench's frames. These cover a ramp, a full-scale frame, and two hashed patterns with stalls. Against them the bench shows the lane values, the zero padding at row ends and at the frame top, the absence of carry-over between rows, and the per-frame beat count.

// File: rtl/stn_pack_pkg.sv
`timescale 1ns/1ps
package stn_pack_pkg;

   // index width that stays at least one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // result width of a (2r+1)x(2r+1) sum of pw-bit pixels
   function automatic int unsigned sum_w(input int unsigned pw, input int unsigned r);
      return pw + $clog2((2 * r + 1) * (2 * r + 1));
   endfunction

endpackage

// File: rtl/stn_pack_seq.sv
`timescale 1ns/1ps
module stn_pack_seq
   import stn_pack_pkg::*;
#(
   parameter int unsigned BEATS  = 4,
   parameter int unsigned ROWS   = 6,
   parameter int unsigned RADIUS = 1,
   localparam int unsigned CW = idx_w(BEATS),
   localparam int unsigned RW = idx_w(ROWS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_vld,
   output logic [CW-1:0] col_q,
   output logic [RW-1:0] row_q,
   output logic          first,
   output logic          last,
   output logic          row_ok
);

   assign first  = (col_q == '0);
   assign last   = (col_q == CW'(BEATS - 1));
   assign row_ok = (int'(row_q) >= int'(RADIUS));

   always_ff @(posedge clk) begin
      if (rst) begin
         col_q <= '0;
         row_q <= '0;
      end else if (in_vld) begin
         if (last) begin
            col_q <= '0;
            row_q <= (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/stn_pack_linebuf.sv
`timescale 1ns/1ps
module stn_pack_linebuf
   import stn_pack_pkg::*;
#(
   parameter int unsigned PIX_W  = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned RADIUS = 1,
   parameter int unsigned BEATS  = 4,
   localparam int unsigned NR = 2 * RADIUS,
   localparam int unsigned BW = LANES * PIX_W,
   localparam int unsigned CW = idx_w(BEATS)
) (
   input  logic            clk,
   input  logic            in_vld,
   input  logic [CW-1:0]   col,
   input  logic [BW-1:0]   in_pix,
   output logic [NR*BW-1:0] up_rows
);

   // slot k of an entry holds the beat from row (current - 1 - k)
   logic [NR*BW-1:0] mem_q [BEATS];

   assign up_rows = mem_q[col];

   generate
      if (NR > 1) begin : g_deep
         always_ff @(posedge clk) begin
            if (in_vld) mem_q[col] <= {up_rows[(NR-1)*BW-1:0], in_pix};
         end
      end else begin : g_single
         always_ff @(posedge clk) begin
            if (in_vld) mem_q[col] <= in_pix;
         end
      end
   endgenerate

endmodule

// File: rtl/stn_pack_lanes.sv
`timescale 1ns/1ps
module stn_pack_lanes
   import stn_pack_pkg::*;
#(
   parameter int unsigned PIX_W  = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned RADIUS = 1,
   parameter int unsigned ROWS   = 6,
   localparam int unsigned SW = sum_w(PIX_W, RADIUS),
   localparam int unsigned NR = 2 * RADIUS,
   localparam int unsigned KR = NR + 1,
   localparam int unsigned WC = NR + LANES,
   localparam int unsigned BW = LANES * PIX_W,
   localparam int unsigned RW = idx_w(ROWS)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_vld,
   input  logic               first,
   input  logic [RW-1:0]      row_idx,
   input  logic [BW-1:0]      in_pix,
   input  logic [NR*BW-1:0]   up_rows,
   output logic [LANES*SW-1:0] lane_sum,
   output logic [RADIUS*SW-1:0] tail_sum
);

   // window row j = 0 is the oldest row, j = NR is the row arriving now
   logic [PIX_W-1:0] carry_q [KR][NR];
   logic [PIX_W-1:0] win     [KR][WC];
   logic [SW-1:0]    col_sum [WC];
   logic [KR-1:0]    row_on;

   always_comb begin
      for (int j = 0; j < KR; j++) begin
         row_on[j] = (int'(row_idx) + j >= int'(NR));
      end
   end

   // window: NR carried columns followed by the current beat
   always_comb begin
      for (int j = 0; j < KR; j++) begin
         for (int c = 0; c < WC; c++) begin
            if (!row_on[j]) begin
               win[j][c] = '0;
            end else if (c < int'(NR)) begin
               win[j][c] = first ? '0 : carry_q[j][c];
            end else if (j == int'(NR)) begin
               win[j][c] = in_pix[(c-NR)*PIX_W +: PIX_W];
            end else begin
               win[j][c] = up_rows[(NR-1-j)*BW + (c-NR)*PIX_W +: PIX_W];
            end
         end
      end
   end

   always_comb begin
      for (int c = 0; c < WC; c++) begin
         col_sum[c] = '0;
         for (int j = 0; j < KR; j++) begin
            col_sum[c] = col_sum[c] + SW'(win[j][c]);
         end
      end
   end

   // lane i is centred one radius left of beat position i
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [SW-1:0] acc;
         always_comb begin
            acc = '0;
            for (int d = 0; d < KR; d++) begin
               acc = acc + col_sum[i + d];
            end
         end
         assign lane_sum[i*SW +: SW] = acc;
      end

      // tail lanes finish the right end of a row, missing columns are zero
      for (genvar t = 0; t < RADIUS; t++) begin : g_tail
         logic [SW-1:0] acc;
         always_comb begin
            acc = '0;
            for (int d = 0; d < KR; d++) begin
               if (LANES + t + d < WC) begin
                  acc = acc + col_sum[(LANES + t + d < WC) ? LANES + t + d : 0];
               end
            end
         end
         assign tail_sum[t*SW +: SW] = acc;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int j = 0; j < KR; j++) begin
            for (int c = 0; c < NR; c++) carry_q[j][c] <= '0;
         end
      end else if (in_vld) begin
         for (int j = 0; j < KR; j++) begin
            for (int c = 0; c < NR; c++) carry_q[j][c] <= win[j][LANES + c];
         end
      end
   end

endmodule

// File: rtl/stn_pack_packer.sv
`timescale 1ns/1ps
module stn_pack_packer #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned RADIUS = 1,
   parameter int unsigned SW     = 12,
   localparam int unsigned HOLD = LANES - RADIUS
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_vld,
   input  logic                 col_gt0,
   input  logic                 last,
   input  logic                 row_ok,
   input  logic [LANES*SW-1:0]  lane_sum,
   input  logic [RADIUS*SW-1:0] tail_sum,
   output logic                 out_vld,
   output logic [LANES*SW-1:0]  out_sum
);

   logic [HOLD*SW-1:0]   held_q;
   logic [RADIUS*SW-1:0] tail_q;
   logic                 flush_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         held_q  <= '0;
         tail_q  <= '0;
         flush_q <= 1'b0;
         out_vld <= 1'b0;
         out_sum <= '0;
      end else begin
         flush_q <= in_vld && last && row_ok;
         if (in_vld) held_q <= lane_sum[LANES*SW-1 : RADIUS*SW];
         if (in_vld && last) tail_q <= tail_sum;
         if (in_vld && col_gt0 && row_ok) begin
            out_sum <= {lane_sum[RADIUS*SW-1:0], held_q};
            out_vld <= 1'b1;
         end else if (flush_q) begin
            out_sum <= {tail_q, held_q};
            out_vld <= 1'b1;
         end else begin
            out_vld <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/stn_pack_top.sv
`timescale 1ns/1ps
module stn_pack_top
   import stn_pack_pkg::*;
#(
   parameter int unsigned PIX_W  = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned RADIUS = 1,
   parameter int unsigned IMG_W  = 16,
   parameter int unsigned IMG_H  = 6,
   localparam int unsigned SUM_W = sum_w(PIX_W, RADIUS)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_vld,
   input  logic [LANES*PIX_W-1:0] in_pix,
   output logic                   out_vld,
   output logic [LANES*SUM_W-1:0] out_sum
);

   localparam int unsigned BEATS = IMG_W / LANES;
   localparam int unsigned NR    = 2 * RADIUS;
   localparam int unsigned BW    = LANES * PIX_W;
   localparam int unsigned CW    = idx_w(BEATS);
   localparam int unsigned RW    = idx_w(IMG_H);

   initial begin
      assert (RADIUS >= 1 && RADIUS < LANES)
         else $error("stn_pack_top: RADIUS must be in 1..LANES-1");
      assert (IMG_W % LANES == 0 && IMG_W >= LANES)
         else $error("stn_pack_top: IMG_W must be a multiple of LANES");
      assert (IMG_H > RADIUS)
         else $error("stn_pack_top: IMG_H must exceed RADIUS");
   end

   logic [CW-1:0]          col_q;
   logic [RW-1:0]          row_q;
   logic                   first;
   logic                   last;
   logic                   row_ok;
   logic [NR*BW-1:0]       up_rows;
   logic [LANES*SUM_W-1:0] lane_sum;
   logic [RADIUS*SUM_W-1:0] tail_sum;

   stn_pack_seq #(.BEATS(BEATS), .ROWS(IMG_H), .RADIUS(RADIUS)) u_seq (
      .clk(clk), .rst(rst), .in_vld(in_vld), .col_q(col_q), .row_q(row_q),
      .first(first), .last(last), .row_ok(row_ok)
   );

   stn_pack_linebuf #(.PIX_W(PIX_W), .LANES(LANES), .RADIUS(RADIUS), .BEATS(BEATS)) u_lb (
      .clk(clk), .in_vld(in_vld), .col(col_q), .in_pix(in_pix), .up_rows(up_rows)
   );

   stn_pack_lanes #(.PIX_W(PIX_W), .LANES(LANES), .RADIUS(RADIUS), .ROWS(IMG_H)) u_lanes (
      .clk(clk), .rst(rst), .in_vld(in_vld), .first(first), .row_idx(row_q),
      .in_pix(in_pix), .up_rows(up_rows), .lane_sum(lane_sum), .tail_sum(tail_sum)
   );

   stn_pack_packer #(.LANES(LANES), .RADIUS(RADIUS), .SW(SUM_W)) u_pack (
      .clk(clk), .rst(rst), .in_vld(in_vld), .col_gt0(!first), .last(last),
      .row_ok(row_ok), .lane_sum(lane_sum), .tail_sum(tail_sum),
      .out_vld(out_vld), .out_sum(out_sum)
   );

endmodule

// File: rtl/stn_pack_chk.sv
`timescale 1ns/1ps
module stn_pack_chk #(
   parameter int unsigned CW     = 2,
   parameter int unsigned RW     = 3,
   parameter int unsigned BEATS  = 4,
   parameter int unsigned RADIUS = 1,
   parameter int unsigned OW     = 48
) (
   input logic          clk,
   input logic          rst,
   input logic          in_vld,
   input logic [CW-1:0] col_idx,
   input logic [RW-1:0] row_idx,
   input logic          out_vld,
   input logic [OW-1:0] out_sum
);

   a_r1_quiet_after_reset: assert property (@(posedge clk)
      rst |=> !out_vld);

   a_r2_no_beat_in_top_rows: assert property (@(posedge clk) disable iff (rst)
      (in_vld && col_idx != '0 && int'(row_idx) < int'(RADIUS)) |=> !out_vld);

   a_r4_inner_beat_follows: assert property (@(posedge clk) disable iff (rst)
      (in_vld && col_idx != '0 && int'(row_idx) >= int'(RADIUS)) |=> out_vld);

   a_r4_flush_after_last: assert property (@(posedge clk) disable iff (rst)
      (in_vld && col_idx == CW'(BEATS - 1) && int'(row_idx) >= int'(RADIUS)) |-> ##2 out_vld);

   a_r7_hold_while_idle: assert property (@(posedge clk) disable iff (rst)
      !out_vld |-> $stable(out_sum));

endmodule

bind stn_pack_top stn_pack_chk #(
   .CW(CW), .RW(RW), .BEATS(BEATS), .RADIUS(RADIUS), .OW(LANES*SUM_W)
) u_chk (
   .clk(clk), .rst(rst), .in_vld(in_vld), .col_idx(col_q), .row_idx(row_q),
   .out_vld(out_vld), .out_sum(out_sum)
);

// File: tb/stn_pack_top_tb_top.sv
`timescale 1ns/1ps
module stn_pack_top_tb_top;

   localparam int PW    = 8;
   localparam int V     = 4;
   localparam int R     = 1;
   localparam int W     = 16;
   localparam int H     = 6;
   localparam int BEATS = W / V;
   localparam int SW    = PW + $clog2((2*R+1)*(2*R+1));
   localparam int NF    = 4;
   localparam int PER   = (H - R) * BEATS;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic            rst;
   logic            in_vld;
   logic [V*PW-1:0] in_pix;
   logic            out_vld;
   logic [V*SW-1:0] out_sum;

   stn_pack_top #(.PIX_W(PW), .LANES(V), .RADIUS(R), .IMG_W(W), .IMG_H(H)) dut_i (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_pix(in_pix),
      .out_vld(out_vld), .out_sum(out_sum)
   );

   int checks = 0;
   int errors = 0;
   int n_out  = 0;
   bit started = 1'b0;
   bit done    = 1'b0;
   logic drv_vld;
   int   drv_col;
   int   drv_row;
   logic exp_v1, exp_f1, exp_f2;
   logic [V*SW-1:0] prev_sum;

   function automatic int pix(int f, int y, int x);
      if (x < 0 || x >= W || y < 0 || y >= H) return 0;
      case (f % 4)
         0:       return (x + 16 * y) % 256;
         1:       return 255;
         2:       return (x * 37 + y * 91 + 13) % 256;
         default: return (x * x * 7 + y * 53 + (x ^ y) * 11) % 256;
      endcase
   endfunction

   function automatic int ref_sum(int f, int cy, int x);
      int s = 0;
      for (int dy = -R; dy <= R; dy++)
         for (int dx = -R; dx <= R; dx++)
            s += pix(f, cy + dy, x + dx);
      return s;
   endfunction

   task automatic check(bit ok, string tag, longint act, longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // expected valid timing, from the accepted beats (R4)
   always @(posedge clk) begin
      if (rst) begin
         exp_v1 <= 1'b0;
         exp_f1 <= 1'b0;
         exp_f2 <= 1'b0;
      end else begin
         exp_v1 <= drv_vld && drv_col > 0 && drv_row >= R;
         exp_f1 <= drv_vld && drv_col == BEATS - 1 && drv_row >= R;
         exp_f2 <= exp_f1;
      end
   end

   always @(negedge clk) begin
      if (started && !rst) begin
         check(out_vld == (exp_v1 | exp_f2), "R4 valid timing",
               longint'(out_vld), longint'(exp_v1 | exp_f2));
         if (out_vld) begin
            int f, m, cy, k;
            f  = n_out / PER;
            m  = n_out % PER;
            cy = m / BEATS;
            k  = m % BEATS;
            for (int i = 0; i < V; i++) begin
               int e;
               e = ref_sum(f, cy, k * V + i);
               if (f % 4 == 1)
                  check(int'(out_sum[i*SW +: SW]) == e, "R6 full-scale lane",
                        longint'(out_sum[i*SW +: SW]), longint'(e));
               else
                  check(int'(out_sum[i*SW +: SW]) == e, "R3 lane sum",
                        longint'(out_sum[i*SW +: SW]), longint'(e));
            end
            n_out++;
         end else begin
            check(out_sum == prev_sum, "R7 hold while idle",
                  longint'(out_sum), longint'(prev_sum));
         end
         prev_sum = out_sum;
      end
   end

   task automatic drive_beat(int f, int y, int b);
      @(posedge clk);
      #1;
      in_vld = 1'b1;
      for (int i = 0; i < V; i++) in_pix[i*PW +: PW] = PW'(pix(f, y, b * V + i));
      drv_vld = 1'b1;
      drv_col = b;
      drv_row = y;
   endtask

   task automatic idle(int n);
      for (int c = 0; c < n; c++) begin
         @(posedge clk);
         #1;
         in_vld  = 1'b0;
         drv_vld = 1'b0;
      end
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", n_out, NF * PER);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      in_vld = 1'b0;
      in_pix = '0;
      drv_vld = 1'b0;
      drv_col = 0;
      drv_row = 0;
      repeat (3) @(posedge clk);
      #1;
      check(out_vld == 1'b0, "R1 valid low in reset", longint'(out_vld), 0);
      check(out_sum == '0, "R1 sum zero in reset", longint'(out_sum), 0);
      rst = 1'b0;
      @(negedge clk);
      check(out_vld == 1'b0, "R1 valid low after reset", longint'(out_vld), 0);
      prev_sum = out_sum;
      started = 1'b1;

      for (int f = 0; f < NF; f++) begin
         for (int y = 0; y < H; y++) begin
            if (f == 0 && y == R)
               check(n_out == 0, "R2 no beats in top rows", longint'(n_out), 0);
            for (int b = 0; b < BEATS; b++) begin
               if (f >= 2 && (b % 2) == 1) idle(1);
               drive_beat(f, y, b);
            end
            if (f >= 2) idle(2);
         end
      end
      idle(5);
      check(n_out == NF * PER, "R5 beats per frame", longint'(n_out), longint'(NF * PER));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule